// File: doc/BRIEF.md
# Programmable Interrupt Routing Selector

This block steers peripheral interrupt sources onto twelve CPU interrupt lines, numbered 4 to 15. Each line has a 5-bit selector that names one of 32 source numbers. Numbers 4 to 7 belong to four asynchronous external pins. Each pin passes through a two-flop synchronizer and then an optional inversion before it reaches the multiplexer. Numbers 0 to 3 and 8 to 18 come from on-chip, already synchronous request lines. Numbers 19 to 31 give a constant low level.

Every routed line has a rising-edge detector that sets a sticky pending flag. Software clears a flag by writing a 1 to its bit. The detector sits after both the inversion and the multiplexer, so a write to a selector or to a polarity bit can itself produce an edge and set a flag. This behaviour is intended.

The synchronized pins are also sent out, without inversion, as DMA event requests.

Top module: `irq_route_sel`

## Requirements
- R1: After reset, the selectors of lines 4..9 hold sources 4,5,6,7,8,9 and those of lines 10..15 hold 3,10,11,0,1,2. Address 0 reads 0x250718A4, address 1 reads 0x08202D43, address 2 (polarity) reads 0, and no flag is pending.
- R2: Address 0 holds the selectors of lines 4..9 and address 1 those of lines 10..15. In each word the fields sit at bits 4:0, 9:5, 14:10, 20:16, 25:21 and 30:26, in ascending line order. Bits 15 and 31 always read 0. The polarity word at address 2 keeps only bits 3:0, and its bits 31:4 read 0.
- R3: Each line level `irq_lvl[k]` equals the level of the source its selector names. Sources 0..3 come from `int_src[3:0]` and sources 8..18 from `int_src[14:4]`. Source numbers 19..31 give 0.
- R4: Sources 4..7 are external pins 0..3, each synchronized by two flops. Polarity bit i set to 1 inverts pin i on the CPU path only.
- R5: `dma_evt` equals the synchronized pins. It changes on the second clock edge after a pin change, and polarity has no effect on it.
- R6: A 0-to-1 change of a line level sets that line's pending flag on the next clock edge.
- R7: A polarity write that turns a selected pin's routed level from 0 to 1 sets the flag of every line that selects that pin, and of no other line.
- R8: A selector write that moves a line from a low source to a high source sets that line's flag.
- R9: Writing address 3 clears each flag whose bit (line k at bit k) is 1. If a set and a clear arrive in the same cycle, the set wins.
- R10: A flag holds its value when its line falls and when no clear is written. Address 3 reads the flags at bits 15:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_src | input | 15 | On-chip sources 0..3 and 8..18 |
| ext_pin | input | 4 | Asynchronous external pins (sources 4..7) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low mux, 1 high mux, 2 polarity, 3 flag clear |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (same map; 3 reads flags) |
| rd_data | output | 32 | Read data, combinational |
| irq_lvl | output | 12 | Routed level of lines 4..15 (bit 0 = line 4) |
| pend_flag | output | 12 | Pending flags of lines 4..15 |
| dma_evt | output | 4 | Synchronized, uninverted external pins |

## Verification
The routing table is tried with single-bit and all-ones-but-one patterns on the on-chip sources. These show whether the chosen source, rather than a neighbour, reaches the line. Selector numbers 19 and 31 are applied with every source high to prove the reserved range yields 0. External selections are run with each polarity setting, which separates the inverted CPU path from the plain DMA path. Directed sequences then cover the edges that the block creates itself: a polarity flip on a low pin and a remap onto a high source. They also cover a set and a clear landing in the same cycle.

// File: rtl/irq_route_sel.sv
module irq_route_sel #(
  parameter int NLINE = 12,
  parameter int SELW  = 5,
  parameter int NEXT  = 4,
  parameter int NINT  = 15,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NINT-1:0]  int_src,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [NLINE-1:0] irq_lvl,
  output logic [NLINE-1:0] pend_flag,
  output logic [NEXT-1:0]  dma_evt
);
  localparam int NSRC  = 1 << SELW;
  localparam int HALF  = NLINE / 2;
  localparam int FIRST = 4;
  localparam int NPAD  = NSRC - NINT - NEXT;

  function automatic logic [SELW-1:0] dflt_sel(input int k);
    case (k)
      6:  return SELW'(3);
      7:  return SELW'(10);
      8:  return SELW'(11);
      9:  return SELW'(0);
      10: return SELW'(1);
      11: return SELW'(2);
      default: return SELW'(k + FIRST);
    endcase
  endfunction

  function automatic int fld_lsb(input int j);
    return j * SELW + ((j >= 3) ? 1 : 0);
  endfunction

  logic [SELW-1:0] sel [NLINE];
  logic [NEXT-1:0] pol, sync1, sync2;
  logic [NLINE-1:0] prev_lvl, rise;
  logic [NSRC-1:0] src_all;
  logic [NLINE-1:0] clr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= ext_pin;
      sync2 <= sync1;
    end
  end

  assign dma_evt = sync2;
  assign src_all = {{NPAD{1'b0}}, int_src[NINT-1:FIRST], sync2 ^ pol, int_src[FIRST-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) pol <= '0;
    else if (wr_en && wr_addr == 2'd2) pol <= wr_data[NEXT-1:0];
  end

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    localparam int REG = k / HALF;
    localparam int J   = k % HALF;
    always_ff @(posedge clk) begin
      if (!rst_n) sel[k] <= dflt_sel(k);
      else if (wr_en && wr_addr == 2'(REG)) sel[k] <= wr_data[fld_lsb(J) +: SELW];
    end
    assign irq_lvl[k] = src_all[sel[k]];

    p_rsvd_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[k] >= SELW'(19)) |-> !irq_lvl[k]);
    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lvl[k] && !prev_lvl[k]) |=> pend_flag[k]);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3 && wr_data[k+FIRST] && !rise[k]) |=> !pend_flag[k]);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise[k] && !(wr_en && wr_addr == 2'd3)) |=> (pend_flag[k] == $past(pend_flag[k])));
  end

  assign rise     = irq_lvl & ~prev_lvl;
  assign clr_mask = (wr_en && wr_addr == 2'd3) ? wr_data[FIRST +: NLINE] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl  <= '0;
      pend_flag <= '0;
    end else begin
      prev_lvl  <= irq_lvl;
      pend_flag <= (pend_flag & ~clr_mask) | rise;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0, 2'd1:
        for (int j = 0; j < HALF; j++)
          rd_data[fld_lsb(j) +: SELW] = sel[int'(rd_addr) * HALF + j];
      2'd2: rd_data[NEXT-1:0] = pol;
      default: rd_data[FIRST +: NLINE] = pend_flag;
    endcase
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_rsvd_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != 2'd3) |-> (!rd_data[15] && !rd_data[31]));
  p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (dma_evt == $past(ext_pin, 2)));
endmodule

// File: tb/sim_irq_route_sel.sv
module sim_irq_route_sel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] int_src = '0;
  logic [3:0]  ext_pin = '0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [11:0] irq_lvl, pend_flag;
  logic [3:0]  dma_evt;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] LOW_DEF  = 32'h250718A4;
  localparam logic [31:0] HIGH_DEF = 32'h08202D43;

  always #2 clk = ~clk;

  irq_route_sel u0 (.clk, .rst_n, .int_src, .ext_pin, .wr_en, .wr_addr, .wr_data,
                    .rd_addr, .rd_data, .irq_lvl, .pend_flag, .dma_evt);

  // {selector for line 4, int_src, ext_pin, polarity, expected level of line 4}
  typedef struct packed {
    logic [4:0]  sel;
    logic [14:0] src;
    logic [3:0]  ext;
    logic [3:0]  pol;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{5'd0,  15'h0001, 4'h0, 4'h0, 1'b1},
    '{5'd0,  15'h7FFE, 4'h0, 4'h0, 1'b0},
    '{5'd3,  15'h0008, 4'h0, 4'h0, 1'b1},
    '{5'd8,  15'h0010, 4'h0, 4'h0, 1'b1},
    '{5'd18, 15'h4000, 4'h0, 4'h0, 1'b1},
    '{5'd18, 15'h3FFF, 4'hF, 4'h0, 1'b0},
    '{5'd19, 15'h7FFF, 4'hF, 4'h0, 1'b0},
    '{5'd31, 15'h7FFF, 4'hF, 4'hF, 1'b0},
    '{5'd5,  15'h0000, 4'h2, 4'h0, 1'b1},
    '{5'd5,  15'h0000, 4'h2, 4'h2, 1'b0},
    '{5'd6,  15'h0000, 4'h0, 4'h4, 1'b1},
    '{5'd7,  15'h0000, 4'h8, 4'h7, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(2'd0, d); chk("R1 low mux", d, LOW_DEF);
    rd(2'd1, d); chk("R1 high mux", d, HIGH_DEF);
    rd(2'd2, d); chk("R1 polarity", d, 32'h0);
    chk("R1 no pending", {20'h0, pend_flag}, 32'h0);

    // R2 reserved bits
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, d); chk("R2 low reserved zero", d, 32'h7FFF7FFF);
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd2, d); chk("R2 polarity width", d, 32'h0000000F);
    wr(2'd2, 32'h0);
    wr(2'd0, LOW_DEF);

    // R3 R4 table of routing vectors on line 4
    for (int v = 0; v < 12; v++) begin
      wr(2'd2, {28'h0, VECS[v].pol});
      wr(2'd0, (LOW_DEF & ~32'h1F) | {27'h0, VECS[v].sel});
      @(negedge clk);
      int_src = VECS[v].src;
      ext_pin = VECS[v].ext;
      idle(3);
      chk($sformatf("R3/R4 vector %0d line4", v), {31'h0, irq_lvl[0]}, {31'h0, VECS[v].exp});
    end
    rd(2'd0, d); chk("R2 field readback", d, (LOW_DEF & ~32'h1F) | 32'd7);
    int_src = '0; ext_pin = '0;
    wr(2'd2, 32'h0);
    wr(2'd0, LOW_DEF);
    idle(3);
    wr(2'd3, 32'hFFFFFFFF);
    chk("R9 clear all", {20'h0, pend_flag}, 32'h0);

    // R5 sync latency and polarity independence
    wr(2'd2, 32'hF);
    @(negedge clk); ext_pin = 4'h5;
    @(negedge clk); chk("R5 one edge old", {28'h0, dma_evt}, 32'h0);
    @(negedge clk); chk("R5 two edges new", {28'h0, dma_evt}, 32'h5);
    chk("R4 inverted cpu path", {28'h0, irq_lvl[3:0]}, 32'hA);
    ext_pin = 4'h0;
    wr(2'd2, 32'h0);
    idle(3);
    wr(2'd3, 32'hFFFFFFFF);

    // R6 R10 R9 line 13 (index 9) selects source 0
    @(negedge clk); int_src[0] = 1'b1;
    @(negedge clk); chk("R6 rise sets flag", {20'h0, pend_flag}, 32'h200);
    int_src[0] = 1'b0;
    idle(2); chk("R10 flag held after fall", {20'h0, pend_flag}, 32'h200);
    rd(2'd3, d); chk("R10 flag readback", d, 32'h2000);
    wr(2'd3, 32'h0000_2000);
    chk("R9 write one clears", {20'h0, pend_flag}, 32'h0);
    @(negedge clk);
    int_src[0] = 1'b1; wr_en = 1; wr_addr = 2'd3; wr_data = 32'h2000;
    @(negedge clk); wr_en = 0;
    chk("R9 set beats clear", {20'h0, pend_flag}, 32'h200);
    int_src[0] = 1'b0;
    idle(1);
    wr(2'd3, 32'hFFFFFFFF);

    // R7 polarity flip on low pin 4 sets line 4 only
    wr(2'd2, 32'h1);
    @(negedge clk); chk("R7 polarity edge", {20'h0, pend_flag}, 32'h001);
    wr(2'd3, 32'hFFFFFFFF);
    @(negedge clk); ext_pin = 4'h1;
    idle(4); chk("R10 inverted fall no set", {20'h0, pend_flag}, 32'h0);
    ext_pin = 4'h0;
    wr(2'd2, 32'h0);
    idle(3);
    wr(2'd3, 32'hFFFFFFFF);

    // R8 remap line 10 from source 3 (low) to source 12 (high)
    @(negedge clk); int_src[8] = 1'b1;
    idle(1);
    wr(2'd1, (HIGH_DEF & ~32'h1F) | 32'd12);
    @(negedge clk); chk("R8 remap edge", {20'h0, pend_flag}, 32'h040);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule